// File: doc/BRIEF.md
# Arithmetic Right Shift Unit

This unit executes the register form of an arithmetic right shift for a 32-bit integer datapath. Each cycle that `valid_i` is high, it decodes a 16-bit shift instruction word and picks the shift count. The count is either a 3-bit immediate or the low six bits of a count register value supplied by the register file. The unit then shifts the byte, word or long slice of the destination operand right, refilling the top of the slice with its sign bit. It writes the result back into the 32-bit register image and produces the five condition flags: extend, negative, zero, overflow and carry.

The size code that register shifts do not use selects a fixed mode: a word operand shifted right by exactly one bit. This mode serves an operand that was fetched from memory. The destination register index is decoded from the instruction and returned together with the result, so that write-back knows its target. Results are registered and appear one clock after the request.

Top module: `asr_unit`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high, and the result, flags and `rd_o` presented then belong to that request. The outputs hold their values while no request arrives.
- R2: The size comes from `instr_i[7:6]`: 00 is 8 bits, 01 is 16 bits and 10 is 32 bits. Code 11 is the fixed mode, which shifts a 16-bit operand by one bit and ignores `instr_i[11:9]`, `instr_i[5]` and `cnt_reg_i`.
- R3: When `instr_i[5]` is 0, the count is `instr_i[11:9]`. Field values 1 to 7 give counts of 1 to 7, and a field value of 0 gives a count of 8.
- R4: When `instr_i[5]` is 1, the count is `cnt_reg_i[5:0]`, a value from 0 to 63. Bits above bit 5 have no effect.
- R5: Every shift step copies the slice's sign bit into its top position. A count equal to or greater than the slice width leaves every bit of the slice equal to the sign bit.
- R6: For a nonzero count, `c_o` and `x_o` both equal the last bit shifted out of bit 0. When the count is at least the slice width, that bit is the sign bit.
- R7: A count of 0 leaves the operand unchanged, and `x_o` and `c_o` repeat `x_i` and `c_i`.
- R8: `n_o` is the top bit of the shifted slice. `z_o` is high exactly when every bit of the shifted slice is zero.
- R9: `v_o` is always 0.
- R10: For the 8-bit and 16-bit sizes, the bits of `result_o` above the slice equal the same bits of `dest_i`.
- R11: `rd_o` equals `instr_i[2:0]` of the request.
- R12: While `rst_ni` is low, `valid_o`, `result_o`, `rd_o` and every flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| instr_i | input | 16 | Shift instruction word |
| dest_i | input | 32 | Destination register value |
| cnt_reg_i | input | 32 | Value of the register named as the count source |
| x_i | input | 1 | Incoming extend flag |
| c_i | input | 1 | Incoming carry flag |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 32 | Register image after the shift |
| rd_o | output | 3 | Destination register index |
| x_o | output | 1 | Extend flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
All results share one output register stage. The result, the flags and the register index of a request are therefore due together exactly one rising edge after `valid_i` is sampled high. The bench drives each request on a falling edge and compares all outputs on the next falling edge, half a period after the capturing edge. It then drives the next request in that same moment, so the check never overlaps a second request. The expected values come from a bench model that shifts bit by bit. The hold behaviour is checked by sampling after idle cycles, when no new request has been captured.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned CNT_W   = 6;
  localparam int unsigned IMM_W   = 3;
  localparam int unsigned REG_W   = 3;
  localparam int unsigned INSTR_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_FIXED = 2'b11
  } size_code_e;

  typedef enum logic [1:0] {
    OP_8  = 2'd0,
    OP_16 = 2'd1,
    OP_32 = 2'd2
  } op_size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/asr_decode.sv
module asr_decode
  import asr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  cnt_reg_i,
  output op_size_e           op_size_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [REG_W-1:0]   rd_o
);
  localparam int unsigned CNT_F_LSB = 9;
  localparam int unsigned SZ_F_LSB  = 6;
  localparam int unsigned IR_BIT    = 5;

  size_code_e         sz_code;
  logic               use_reg;
  logic [IMM_W-1:0]   imm_field;
  logic [CNT_W-1:0]   imm_cnt;
  logic               unused_bits;

  assign sz_code   = size_code_e'(instr_i[SZ_F_LSB +: 2]);
  assign use_reg   = instr_i[IR_BIT];
  assign imm_field = instr_i[CNT_F_LSB +: IMM_W];
  assign rd_o      = instr_i[REG_W-1:0];

  // field value zero encodes the largest immediate count
  assign imm_cnt = (imm_field == '0) ? CNT_W'(1 << IMM_W) : CNT_W'(imm_field);

  always_comb begin
    unique case (sz_code)
      SZ_BYTE:  op_size_o = OP_8;
      SZ_WORD:  op_size_o = OP_16;
      SZ_LONG:  op_size_o = OP_32;
      default:  op_size_o = OP_16;
    endcase
  end

  always_comb begin
    if (sz_code == SZ_FIXED) cnt_o = CNT_W'(1);
    else if (use_reg)        cnt_o = cnt_reg_i[CNT_W-1:0];
    else                     cnt_o = imm_cnt;
  end

  assign unused_bits = ^{instr_i[INSTR_W-1:CNT_F_LSB+IMM_W], instr_i[8],
                         instr_i[IR_BIT-1:REG_W], cnt_reg_i[DATA_W-1:CNT_W]};
endmodule

// File: rtl/asr_shifter.sv
module asr_shifter
  import asr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0]     opnd_i,
  input  op_size_e         op_size_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]     merged_o,
  output logic             carry_o
);
  localparam int unsigned EXT_W = 2 * W;

  logic             sign;
  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] shifted;
  logic [CNT_W-1:0] cnt_m1;

  always_comb begin
    unique case (op_size_i)
      OP_8:    sign = opnd_i[BYTE_W-1];
      OP_16:   sign = opnd_i[WORD_W-1];
      default: sign = opnd_i[W-1];
    endcase
  end

  // sign-extend the active slice to twice the width so any count up to 63 indexes it
  always_comb begin
    unique case (op_size_i)
      OP_8:    ext = {{(EXT_W-BYTE_W){sign}}, opnd_i[BYTE_W-1:0]};
      OP_16:   ext = {{(EXT_W-WORD_W){sign}}, opnd_i[WORD_W-1:0]};
      default: ext = {{(EXT_W-W){sign}}, opnd_i};
    endcase
  end

  assign shifted = EXT_W'($signed(ext) >>> cnt_i);
  assign cnt_m1  = cnt_i - CNT_W'(1);
  assign carry_o = (cnt_i == '0) ? 1'b0 : ext[cnt_m1];

  always_comb begin
    unique case (op_size_i)
      OP_8:    merged_o = {opnd_i[W-1:BYTE_W], shifted[BYTE_W-1:0]};
      OP_16:   merged_o = {opnd_i[W-1:WORD_W], shifted[WORD_W-1:0]};
      default: merged_o = shifted[W-1:0];
    endcase
  end
endmodule

// File: rtl/asr_flags.sv
module asr_flags
  import asr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] merged_i,
  input  op_size_e     op_size_i,
  input  logic         cnt_zero_i,
  input  logic         carry_i,
  input  logic         x_i,
  input  logic         c_i,
  output ccr_t         ccr_o
);
  logic msb;
  logic is_zero;

  always_comb begin
    unique case (op_size_i)
      OP_8: begin
        msb     = merged_i[BYTE_W-1];
        is_zero = (merged_i[BYTE_W-1:0] == '0);
      end
      OP_16: begin
        msb     = merged_i[WORD_W-1];
        is_zero = (merged_i[WORD_W-1:0] == '0);
      end
      default: begin
        msb     = merged_i[W-1];
        is_zero = (merged_i == '0);
      end
    endcase
  end

  always_comb begin
    ccr_o.n = msb;
    ccr_o.z = is_zero;
    ccr_o.v = 1'b0;  // sign refill never alters the top bit
    ccr_o.x = cnt_zero_i ? x_i : carry_i;
    ccr_o.c = cnt_zero_i ? c_i : carry_i;
  end
endmodule

// File: rtl/asr_unit.sv
module asr_unit
  import asr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  dest_i,
  input  logic [DATA_W-1:0]  cnt_reg_i,
  input  logic               x_i,
  input  logic               c_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  result_o,
  output logic [REG_W-1:0]   rd_o,
  output logic               x_o,
  output logic               n_o,
  output logic               z_o,
  output logic               v_o,
  output logic               c_o
);
  op_size_e          op_size;
  logic [CNT_W-1:0]  cnt;
  logic [REG_W-1:0]  rd_d;
  logic [DATA_W-1:0] merged;
  logic              carry;
  ccr_t              ccr_d;
  ccr_t              ccr_q;

  asr_decode u_dec (
    .instr_i   (instr_i),
    .cnt_reg_i (cnt_reg_i),
    .op_size_o (op_size),
    .cnt_o     (cnt),
    .rd_o      (rd_d)
  );

  asr_shifter #(.W(DATA_W)) u_shf (
    .opnd_i    (dest_i),
    .op_size_i (op_size),
    .cnt_i     (cnt),
    .merged_o  (merged),
    .carry_o   (carry)
  );

  asr_flags #(.W(DATA_W)) u_flg (
    .merged_i   (merged),
    .op_size_i  (op_size),
    .cnt_zero_i (cnt == '0),
    .carry_i    (carry),
    .x_i        (x_i),
    .c_i        (c_i),
    .ccr_o      (ccr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      rd_o     <= '0;
      ccr_q    <= '0;
    end else if (valid_i) begin
      result_o <= merged;
      rd_o     <= rd_d;
      ccr_q    <= ccr_d;
    end
  end

  assign x_o = ccr_q.x;
  assign n_o = ccr_q.n;
  assign z_o = ccr_q.z;
  assign v_o = ccr_q.v;
  assign c_o = ccr_q.c;
endmodule

// File: rtl/asr_unit_chk.sv
module asr_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [15:0] instr_i,
  input logic [31:0] dest_i,
  input logic [31:0] cnt_reg_i,
  input logic        x_i,
  input logic        c_i,
  input logic        valid_o,
  input logic [31:0] result_o,
  input logic [2:0]  rd_o,
  input logic        x_o,
  input logic        n_o,
  input logic        z_o,
  input logic        v_o,
  input logic        c_o
);
  logic reg_cnt_zero;
  logic fixed_sz;
  assign reg_cnt_zero = instr_i[5] && (cnt_reg_i[5:0] == 6'd0);
  assign fixed_sz     = (instr_i[7:6] == 2'b11);

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(rd_o));

  a_r9_v_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !v_o);

  a_r7_keep_xc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && reg_cnt_zero && !fixed_sz |=> x_o == $past(x_i) && c_o == $past(c_i)
      && result_o == $past(dest_i));

  a_r6_x_eq_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !reg_cnt_zero |=> x_o == c_o);

  a_r10_upper_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[7:6] == 2'b00 |=> result_o[31:8] == $past(dest_i[31:8]));

  a_r8_n_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[7:6] == 2'b00 |=> n_o == result_o[7]);

  a_r11_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> rd_o == $past(instr_i[2:0]));

  a_r12_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o && result_o == '0);
endmodule

bind asr_unit asr_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .dest_i    (dest_i),
  .cnt_reg_i (cnt_reg_i),
  .x_i       (x_i),
  .c_i       (c_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .rd_o      (rd_o),
  .x_o       (x_o),
  .n_o       (n_o),
  .z_o       (z_o),
  .v_o       (v_o),
  .c_o       (c_o)
);

// File: tb/tb_asr_unit.sv
module tb_asr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [31:0] dest_i = '0;
  logic [31:0] cnt_reg_i = '0;
  logic        x_i = 1'b0;
  logic        c_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [2:0]  rd_o;
  logic        x_o, n_o, z_o, v_o, c_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  asr_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .dest_i(dest_i), .cnt_reg_i(cnt_reg_i), .x_i(x_i), .c_i(c_i),
    .valid_o(valid_o), .result_o(result_o), .rd_o(rd_o),
    .x_o(x_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bit-serial model: returns {result, x, n, z, v, c}
  function automatic logic [36:0] model(input logic [15:0] ins, input logic [31:0] d,
                                        input logic [31:0] cr, input logic xi, input logic ci);
    int w, cnt;
    logic [31:0] op, mask, res;
    logic sgn, out, xo, co;
    case (ins[7:6])
      2'b00: w = 8;
      2'b01: w = 16;
      2'b10: w = 32;
      default: w = 16;
    endcase
    if (ins[7:6] == 2'b11) cnt = 1;
    else if (ins[5]) cnt = int'(cr[5:0]);
    else cnt = (ins[11:9] == 3'd0) ? 8 : int'(ins[11:9]);
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    op = d & mask;
    sgn = op[w-1];
    out = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      out = op[0];
      op = (op >> 1) | ({31'd0, sgn} << (w - 1));
    end
    res = (d & ~mask) | op;
    xo = (cnt == 0) ? xi : out;
    co = (cnt == 0) ? ci : out;
    return {res, xo, op[w-1], (op == 32'd0), 1'b0, co};
  endfunction

  task automatic run(input logic [15:0] ins, input logic [31:0] d, input logic [31:0] cr,
                     input logic xi, input logic ci, input string tag);
    logic [36:0] e;
    e = model(ins, d, cr, xi, ci);
    valid_i = 1'b1; instr_i = ins; dest_i = d; cnt_reg_i = cr; x_i = xi; c_i = ci;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({tag, " R1 valid"}, {31'd0, valid_o}, 32'd1);
    check({tag, " R5 R7 R10 result"}, result_o, e[36:5]);
    check({tag, " R6 R7 x"}, {31'd0, x_o}, {31'd0, e[4]});
    check({tag, " R6 R7 c"}, {31'd0, c_o}, {31'd0, e[0]});
    check({tag, " R8 n"}, {31'd0, n_o}, {31'd0, e[3]});
    check({tag, " R8 z"}, {31'd0, z_o}, {31'd0, e[2]});
    check({tag, " R9 v"}, {31'd0, v_o}, 32'd0);
    check({tag, " R11 rd"}, {29'd0, rd_o}, {29'd0, ins[2:0]});
  endtask

  function automatic logic [15:0] mk(input logic [2:0] cf, input logic [1:0] sz,
                                     input logic ir, input logic [2:0] rd);
    return {4'hE, cf, 1'b0, sz, ir, 2'b00, rd};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R12 reset valid", {31'd0, valid_o}, 32'd0);
    check("R12 reset result", result_o, 32'd0);
    check("R12 reset flags", {27'd0, x_o, n_o, z_o, v_o, c_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 immediate zero means eight; R2 byte size
    run(mk(3'd0, 2'b00, 1'b0, 3'd1), 32'h1234_5680, 32'd0, 1'b0, 1'b0, "R3 R2 imm8 byte");
    run(mk(3'd3, 2'b01, 1'b0, 3'd2), 32'hAAAA_800C, 32'd0, 1'b0, 1'b0, "R3 word imm3");
    // R7 register count zero keeps x/c
    run(mk(3'd4, 2'b10, 1'b1, 3'd3), 32'h8000_0001, 32'hFFFF_FFC0, 1'b1, 1'b0, "R7 R4 cnt0");
    // R4 upper count bits ignored, R5 R6 count beyond width
    run(mk(3'd4, 2'b10, 1'b1, 3'd4), 32'h8000_0000, 32'h0000_0068, 1'b0, 1'b0, "R4 R5 R6 long 40");
    run(mk(3'd4, 2'b00, 1'b1, 3'd5), 32'hFFFF_FF7F, 32'h0000_0009, 1'b1, 1'b1, "R5 R6 byte 9 pos");
    run(mk(3'd4, 2'b01, 1'b1, 3'd6), 32'h0000_8000, 32'h0000_003F, 1'b0, 1'b0, "R5 R6 word 63 neg");
    // R2 fixed word by one
    run(16'hE0F7, 32'h5555_0003, 32'h0000_0000, 1'b0, 1'b0, "R2 fixed");
    run(mk(3'd7, 2'b11, 1'b1, 3'd0), 32'h0001_8001, 32'h0000_0020, 1'b0, 1'b0, "R2 fixed ignores count");
    run(mk(3'd1, 2'b00, 1'b0, 3'd7), 32'hDEAD_BE01, 32'd0, 1'b0, 1'b0, "R10 R8 zero byte");
    run(mk(3'd0, 2'b10, 1'b0, 3'd0), 32'h0000_0000, 32'd0, 1'b1, 1'b1, "R8 z long");

    // R1 hold while idle
    hold = result_o;
    repeat (3) @(negedge clk_i);
    check("R1 idle valid low", {31'd0, valid_o}, 32'd0);
    check("R1 idle hold result", result_o, hold);

    for (int k = 0; k < 400; k++) begin
      logic [15:0] ins;
      logic [31:0] cr;
      ins = mk(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
      cr = $urandom();
      if ($urandom_range(0, 3) == 0) cr[5:0] = 6'd0;
      run(ins, $urandom(), cr, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule